// File: doc/BRIEF.md
# Four-Word Serial Compare-Exchange Sorter

This block puts four unsigned words into ascending order using a single compare-exchange unit. The unit is reused over a fixed sequence of six clock steps. A pulse on the start input captures the four input words into snapshot registers. A step controller then walks the shared unit through six pair operations on four working registers. Each step reads one pair, orders it, and writes the smaller value to the lower lane and the larger value to the upper lane.

After the last step, one emit cycle copies the working registers into the output registers and raises the completion flag. The outputs keep that result until the next sort completes. The completion flag stays high until it is cleared, either by the separate clear input or by the next accepted start.

The block suits places where area matters more than latency. The cost is one comparator and two operand multiplexers, and a sort takes seven cycles from the accepting edge to a valid result.

Top module: `serial_cx_sort4`

## Requirements
- R1: When start_i is high on a rising edge while the block is idle, the four inputs are captured on that edge and done_o is low after it. Inputs changed after that edge have no effect on the result.
- R2: The result appears on the seventh rising edge after the accepting edge, and done_o goes high on that same edge. done_o stays low on edges one to six.
- R3: out_a_o through out_d_o hold the four captured words in ascending order (out_a_o smallest, out_d_o largest) and are a permutation of them. Equal words are kept.
- R4: Words are compared as unsigned values of WIDTH bits (default 16), so a word with its top bit set orders above every word without it.
- R5: The outputs hold the previous result unchanged while a new sort is in progress, until its emit edge.
- R6: A start_i pulse during a sort in progress is ignored: the result and the timing of the running sort are unchanged, and no second sort is started.
- R7: With start_i low, clr_done_i high on an edge while idle makes done_o low after that edge; the outputs are unchanged.
- R8: With start_i and clr_done_i both low, done_o keeps its value.
- R9: rst_ni low asynchronously clears done_o, all outputs and all internal registers, and returns the controller to idle.
- R10: done_o is set on the emit edge even if clr_done_i is high in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start a sort (accepted only when idle) |
| clr_done_i | input | 1 | Clear the completion flag |
| in_a_i | input | WIDTH | Input word 0 |
| in_b_i | input | WIDTH | Input word 1 |
| in_c_i | input | WIDTH | Input word 2 |
| in_d_i | input | WIDTH | Input word 3 |
| out_a_o | output | WIDTH | Smallest word |
| out_b_o | output | WIDTH | Second word |
| out_c_o | output | WIDTH | Third word |
| out_d_o | output | WIDTH | Largest word |
| done_o | output | 1 | Completion flag |

## Verification
The ordering is exercised with several directed input patterns, each of which exposes a different fault:
- Already sorted and fully reversed inputs catch a wrong step order or swapped write-back lanes.
- All-equal inputs and inputs with duplicates show whether equal values survive without loss.
- A pair of words differing only in the top bit (0x8000 against 0x7FFF), and the extremes 0 and 0xFFFF, tell an unsigned compare from a signed one.

Seeded random words cover general permutations. During each sort the inputs are scrambled after the capture edge, which separates true capture from a live read of the inputs. Further cases cover a start pulse injected mid-sort, a clear held across the emit cycle, and a reset in the middle of a sort, each of which isolates one controller priority.

// File: rtl/cxs_pkg.sv
package cxs_pkg;
  localparam int unsigned LANES = 4;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_P0   = 3'd1,
    ST_P1   = 3'd2,
    ST_P2   = 3'd3,
    ST_P3   = 3'd4,
    ST_P4   = 3'd5,
    ST_P5   = 3'd6,
    ST_EMIT = 3'd7
  } step_e;

  typedef enum logic [1:0] {
    PR_AB = 2'd0,
    PR_CD = 2'd1,
    PR_BC = 2'd2
  } pair_e;
endpackage

// File: rtl/cxs_cmpx.sv
module cxs_cmpx #(
  parameter int unsigned WIDTH = 16
) (
  input  logic [WIDTH-1:0] x_i,
  input  logic [WIDTH-1:0] y_i,
  output logic [WIDTH-1:0] lo_o,
  output logic [WIDTH-1:0] hi_o
);
  logic swap;

  always_comb begin
    swap = (x_i > y_i);
    lo_o = swap ? y_i : x_i;
    hi_o = swap ? x_i : y_i;
  end
endmodule

// File: rtl/cxs_ctrl.sv
module cxs_ctrl
  import cxs_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  start_i,
  input  logic  clr_i,
  output logic  load_o,
  output logic  step_o,
  output pair_e pair_o,
  output logic  from_snap_o,
  output logic  emit_o,
  output logic  done_o
);
  step_e state_q, state_d;
  logic  done_q, done_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (start_i) state_d = ST_P0;
      ST_P0:   state_d = ST_P1;
      ST_P1:   state_d = ST_P2;
      ST_P2:   state_d = ST_P3;
      ST_P3:   state_d = ST_P4;
      ST_P4:   state_d = ST_P5;
      ST_P5:   state_d = ST_EMIT;
      ST_EMIT: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_comb begin
    load_o      = (state_q == ST_IDLE) && start_i;
    emit_o      = (state_q == ST_EMIT);
    step_o      = (state_q != ST_IDLE) && (state_q != ST_EMIT);
    from_snap_o = (state_q == ST_P0) || (state_q == ST_P1);
    unique case (state_q)
      ST_P1, ST_P4: pair_o = PR_CD;
      ST_P2, ST_P5: pair_o = PR_BC;
      default:      pair_o = PR_AB;
    endcase
  end

  always_comb begin
    if (load_o)      done_d = 1'b0;
    else if (emit_o) done_d = 1'b1;
    else if (clr_i)  done_d = 1'b0;
    else             done_d = done_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= done_d;
    end
  end

  assign done_o = done_q;

  // R1: an accepted start clears the flag on its edge
  p_start_clears_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE && start_i) |=> !done_o);

  // R2: six steps in order, then the emit cycle
  p_p5_to_emit_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_P5) |=> (state_q == ST_EMIT));
  p_p0_to_p1_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_P0) |=> (state_q == ST_P1));
  p_done_rise_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_q) |-> $past(state_q == ST_EMIT));
  p_one_action_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({load_o, step_o, emit_o}));

  // R6: no sort starts except from idle
  p_busy_ignore_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != ST_IDLE) |=> (state_q != ST_P0));

  // R7: clear while idle without start
  p_clear_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE && !start_i && clr_i) |=> !done_o);

  // R8: flag holds with no request
  p_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE && !start_i && !clr_i) |=> $stable(done_o));

  // R10: the emit edge sets the flag regardless of clear
  p_emit_sets_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_EMIT) |=> done_o);
endmodule

// File: rtl/cxs_dpath.sv
module cxs_dpath
  import cxs_pkg::*;
#(
  parameter int unsigned WIDTH = 16
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        load_i,
  input  logic                        step_i,
  input  pair_e                       pair_i,
  input  logic                        from_snap_i,
  input  logic                        emit_i,
  input  logic [LANES-1:0][WIDTH-1:0] in_i,
  output logic [LANES-1:0][WIDTH-1:0] out_o
);
  logic [LANES-1:0][WIDTH-1:0] snap_q;
  logic [LANES-1:0][WIDTH-1:0] work_q;
  logic [LANES-1:0][WIDTH-1:0] work_wd;
  logic [LANES-1:0]            work_we;
  logic [LANES-1:0][WIDTH-1:0] out_q;
  logic [WIDTH-1:0]            op_x, op_y, res_lo, res_hi;

  // operand selection: x from {snap0, snap2, work0, work1, work2},
  // y from {snap1, snap3, work1, work2, work3}
  always_comb begin
    unique case (pair_i)
      PR_AB: begin
        op_x = from_snap_i ? snap_q[0] : work_q[0];
        op_y = from_snap_i ? snap_q[1] : work_q[1];
      end
      PR_CD: begin
        op_x = from_snap_i ? snap_q[2] : work_q[2];
        op_y = from_snap_i ? snap_q[3] : work_q[3];
      end
      PR_BC: begin
        op_x = work_q[1];
        op_y = work_q[2];
      end
      default: begin
        op_x = work_q[0];
        op_y = work_q[1];
      end
    endcase
  end

  cxs_cmpx #(.WIDTH(WIDTH)) u_cmpx (
    .x_i  (op_x),
    .y_i  (op_y),
    .lo_o (res_lo),
    .hi_o (res_hi)
  );

  // write-back steering
  always_comb begin
    work_we[0] = step_i && (pair_i == PR_AB);
    work_we[1] = step_i && ((pair_i == PR_AB) || (pair_i == PR_BC));
    work_we[2] = step_i && ((pair_i == PR_CD) || (pair_i == PR_BC));
    work_we[3] = step_i && (pair_i == PR_CD);
    work_wd[0] = res_lo;
    work_wd[1] = (pair_i == PR_AB) ? res_hi : res_lo;
    work_wd[2] = (pair_i == PR_CD) ? res_lo : res_hi;
    work_wd[3] = res_hi;
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        snap_q[g] <= '0;
        work_q[g] <= '0;
        out_q[g]  <= '0;
      end else begin
        if (load_i)     snap_q[g] <= in_i[g];
        if (work_we[g]) work_q[g] <= work_wd[g];
        if (emit_i)     out_q[g]  <= work_q[g];
      end
    end
  end

  assign out_o = out_q;

  // R3: a middle-pair step leaves lanes 1 and 2 ordered
  p_mid_order_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && pair_i == PR_BC) |=> (work_q[1] <= work_q[2]));

  // R3: emitted result is ascending
  p_out_sorted_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    emit_i |=> ((out_q[0] <= out_q[1]) && (out_q[1] <= out_q[2]) &&
                (out_q[2] <= out_q[3])));

  // R5: outputs change only on the emit edge
  p_out_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !emit_i |=> $stable(out_q));
endmodule

// File: rtl/serial_cx_sort4.sv
module serial_cx_sort4
  import cxs_pkg::*;
#(
  parameter int unsigned WIDTH = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             clr_done_i,
  input  logic [WIDTH-1:0] in_a_i,
  input  logic [WIDTH-1:0] in_b_i,
  input  logic [WIDTH-1:0] in_c_i,
  input  logic [WIDTH-1:0] in_d_i,
  output logic [WIDTH-1:0] out_a_o,
  output logic [WIDTH-1:0] out_b_o,
  output logic [WIDTH-1:0] out_c_o,
  output logic [WIDTH-1:0] out_d_o,
  output logic             done_o
);
  logic                        load, step, from_snap, emit;
  pair_e                       pair;
  logic [LANES-1:0][WIDTH-1:0] in_vec, out_vec;

  assign in_vec = {in_d_i, in_c_i, in_b_i, in_a_i};

  cxs_ctrl u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_i),
    .clr_i       (clr_done_i),
    .load_o      (load),
    .step_o      (step),
    .pair_o      (pair),
    .from_snap_o (from_snap),
    .emit_o      (emit),
    .done_o      (done_o)
  );

  cxs_dpath #(.WIDTH(WIDTH)) u_dpath (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .load_i      (load),
    .step_i      (step),
    .pair_i      (pair),
    .from_snap_i (from_snap),
    .emit_i      (emit),
    .in_i        (in_vec),
    .out_o       (out_vec)
  );

  assign out_a_o = out_vec[0];
  assign out_b_o = out_vec[1];
  assign out_c_o = out_vec[2];
  assign out_d_o = out_vec[3];
endmodule

// File: tb/serial_cx_sort4_tb_top.sv
module serial_cx_sort4_tb_top;
  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst_ni = 1'b0;
  logic         start = 1'b0;
  logic         clr = 1'b0;
  logic [W-1:0] ia = '0, ib = '0, ic = '0, id = '0;
  logic [W-1:0] oa, ob, oc, od;
  logic         done;
  int           total = 0;
  int           bad = 0;
  logic [4*W-1:0] prev_exp = '0;

  always #4 clk = ~clk;

  serial_cx_sort4 #(.WIDTH(W)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start), .clr_done_i(clr),
    .in_a_i(ia), .in_b_i(ib), .in_c_i(ic), .in_d_i(id),
    .out_a_o(oa), .out_b_o(ob), .out_c_o(oc), .out_d_o(od), .done_o(done)
  );

  function automatic logic [4*W-1:0] sorted4(input logic [W-1:0] a, b, c, d);
    logic [W-1:0] s [4];
    logic [W-1:0] t;
    s[0] = a; s[1] = b; s[2] = c; s[3] = d;
    for (int i = 0; i < 3; i++)
      for (int j = 0; j < 3 - i; j++)
        if (s[j] > s[j+1]) begin
          t = s[j]; s[j] = s[j+1]; s[j+1] = t;
        end
    return {s[0], s[1], s[2], s[3]};
  endfunction

  task automatic check(input string tag, input logic [4*W-1:0] act,
                       input logic [4*W-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // one full sort; poke injects a start mid-sort, hold_clr keeps clear high
  task automatic do_sort(input logic [W-1:0] a, b, c, d, input string tag,
                         input bit poke, input bit hold_clr);
    logic [4*W-1:0] exp;
    exp = sorted4(a, b, c, d);
    @(negedge clk);
    ia = a; ib = b; ic = c; id = d; start = 1'b1; clr = hold_clr;
    @(negedge clk);
    start = 1'b0;
    ia = W'($urandom); ib = W'($urandom); ic = W'($urandom); id = W'($urandom);
    check({"R1 done low after capture ", tag}, {63'd0, done}, 64'd0);
    for (int i = 1; i <= 6; i++) begin
      @(negedge clk);
      if (poke && i == 2) begin
        start = 1'b1; ia = '1; ib = '0; ic = '1; id = '0;
      end else begin
        start = 1'b0;
      end
      if (i == 6) begin
        check({"R2 done low before emit ", tag}, {63'd0, done}, 64'd0);
        check({"R5 outputs held ", tag}, {oa, ob, oc, od}, prev_exp);
      end
    end
    @(negedge clk);
    check({hold_clr ? "R10 done set on emit " : "R2 done set on emit ", tag},
          {63'd0, done}, 64'd1);
    check({poke ? "R6 result " : "R3 result ", tag}, {oa, ob, oc, od}, exp);
    prev_exp = exp;
    @(negedge clk);
    clr = 1'b0;
    if (hold_clr)
      check({"R7 clear after emit ", tag}, {63'd0, done}, 64'd0);
    else
      check({"R8 done holds ", tag}, {63'd0, done}, 64'd1);
    if (poke)
      check({"R6 no second sort ", tag}, {oa, ob, oc, od}, exp);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    check("R9 reset outputs", {oa, ob, oc, od}, '0);
    check("R9 reset done", {63'd0, done}, 64'd0);
    rst_ni = 1'b1;

    do_sort(16'd1, 16'd2, 16'd3, 16'd4, "sorted", 0, 0);
    do_sort(16'd40, 16'd30, 16'd20, 16'd10, "reversed", 0, 0);
    do_sort(16'd7, 16'd7, 16'd7, 16'd7, "all equal", 0, 0);
    do_sort(16'd5, 16'd9, 16'd5, 16'd1, "duplicates", 0, 0);
    do_sort(16'h8000, 16'h7FFF, 16'h0001, 16'hFFFE, "R4 top bit", 0, 0);
    do_sort(16'hFFFF, 16'h0000, 16'hFFFF, 16'h0000, "R4 extremes", 0, 0);
    do_sort(16'd300, 16'd100, 16'd400, 16'd200, "mid-sort start", 1, 0);
    do_sort(16'd3, 16'd1, 16'd4, 16'd2, "clear held", 0, 1);

    // R7: clear while idle leaves outputs alone
    do_sort(16'd12, 16'd11, 16'd14, 16'd13, "before clear", 0, 0);
    @(negedge clk); clr = 1'b1;
    @(negedge clk); clr = 1'b0;
    check("R7 done cleared", {63'd0, done}, 64'd0);
    check("R7 outputs kept", {oa, ob, oc, od}, prev_exp);
    @(negedge clk);
    check("R8 cleared flag holds", {63'd0, done}, 64'd0);

    for (int k = 0; k < 20; k++)
      do_sort(W'($urandom), W'($urandom), W'($urandom), W'($urandom),
              "random", 0, 0);

    // R9: reset in the middle of a sort
    @(negedge clk);
    ia = 16'd9; ib = 16'd8; ic = 16'd7; id = 16'd6; start = 1'b1;
    @(negedge clk); start = 1'b0;
    repeat (2) @(negedge clk);
    rst_ni = 1'b0;
    #1;
    check("R9 mid-sort reset outputs", {oa, ob, oc, od}, '0);
    check("R9 mid-sort reset done", {63'd0, done}, 64'd0);
    @(negedge clk); rst_ni = 1'b1;
    repeat (8) @(negedge clk);
    check("R9 no sort resumes after reset", {63'd0, done}, 64'd0);
    prev_exp = '0;
    do_sort(16'd2, 16'd1, 16'd2, 16'd1, "after reset", 0, 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule